// File: doc/BRIEF.md
# High-Resolution PWM Generator

This block drives a set of PWM output pins from a common time base. The timer moves forward once every four input clocks. Each channel's duty value carries two fractional bits below the timer count, so a channel's falling edge can land on any input clock, not only on a timer tick. Pulse width therefore resolves to a single input clock, which is four times finer than the tick.

Software writes duty values into a per-channel buffer. The buffer moves into the active compare value only at the start of a period, so a new duty never cuts or stretches the pulse in progress. At each period start every pin with a non-zero duty goes high. It goes low again when the timer position, in input clocks, reaches the active duty. A one-clock strobe marks each period start. An enable input and a synchronous timer-restart input control the time base.

Top module: `hp_pwm_gen`

## Requirements
- R1: While enable_i is high, period_start_o is high for exactly one clock out of every 4*max(period_i,1) clocks. A value of 0 on period_i is treated as 1.
- R2: One clock after enable_i is sampled low, pwm_o and period_start_o are all low and the time base is held at its origin. The first strobe appears in the clock that follows the first edge at which enable_i is sampled high.
- R3: A duty value D (wr_data_i) has its upper CNT_W bits as the tick count and its low 2 bits as the input-clock offset within a tick. The pin is high for exactly D clocks, starting with the strobe clock. D=0 keeps the pin low for the whole period. D >= 4*period keeps it high without a gap.
- R4: A pin rises only in a clock in which period_start_o is high.
- R5: A write accepted in the middle of a period leaves the current pulse unchanged. It takes effect from the next strobe.
- R6: A write sampled on the same edge that raises period_start_o applies only from the strobe after that one.
- R7: wr_sel_i picks channel wr_sel_i. A write with wr_sel_i >= NCH changes no channel.
- R8: When tmr_clr_i is sampled high at an edge, the pins keep their current course through the next clock. period_start_o rises one clock after that, starting a fresh period.
- R9: After reset, all pins and the strobe are low, and all buffered and active duty values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Enables the time base and the outputs |
| tmr_clr_i | input | 1 | Synchronous restart of the time base |
| period_i | input | CNT_W | PWM period in timer ticks |
| wr_en_i | input | 1 | Duty buffer write strobe |
| wr_sel_i | input | SEL_W | Channel index of the write |
| wr_data_i | input | CNT_W+2 | Duty value: tick count and 2 fractional bits |
| pwm_o | output | NCH | PWM pins |
| period_start_o | output | 1 | One-clock strobe at each period start |

## Verification
The hardest cases to reach from the ports are a duty write that lands on the exact edge where the period restarts, and a timer restart issued in the middle of a pulse. In both cases one clock of misalignment changes the result. The stimulus keeps its own count of clock positions within the period. It uses that count to schedule a write on the restart edge and a restart at a chosen position, and it predicts each sampled clock's strobe and pin levels from the requirement formulas before comparing.

// File: rtl/hp_pwm_pkg.sv
package hp_pwm_pkg;
  localparam int unsigned FRAC_W = 2;            // input clocks per tick = 2**FRAC_W
  typedef logic [FRAC_W-1:0] phase_t;
endpackage

// File: rtl/hp_pwm_timebase.sv
module hp_pwm_timebase
  import hp_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] tmr_o,
  output phase_t           ph_o,
  output logic             load_o
);
  logic [CNT_W-1:0] tmr_q;
  phase_t           ph_q;
  logic             wrap;

  // last input clock of the last tick; period 0 behaves as 1
  assign wrap = (ph_q == '1) &&
                (({1'b0, tmr_q} + (CNT_W+1)'(1)) >= {1'b0, period_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      ph_q  <= '0;
    end else if (!en_i || clr_i || wrap) begin
      tmr_q <= '0;
      ph_q  <= '0;
    end else begin
      ph_q <= ph_q + phase_t'(1);
      if (ph_q == '1) tmr_q <= tmr_q + CNT_W'(1);
    end
  end

  assign tmr_o  = tmr_q;
  assign ph_o   = ph_q;
  assign load_o = en_i && (tmr_q == '0) && (ph_q == '0);
endmodule

// File: rtl/hp_pwm_duty_buf.sv
module hp_pwm_duty_buf #(
  parameter int unsigned DUTY_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DUTY_W-1:0] data_i,
  input  logic              load_i,
  output logic [DUTY_W-1:0] shadow_o,
  output logic [DUTY_W-1:0] active_o
);
  logic [DUTY_W-1:0] shadow_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_i)   shadow_q <= data_i;
      if (load_i) active_q <= shadow_q;   // pre-edge shadow: same-edge write waits a period
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;
endmodule

// File: rtl/hp_pwm_out_stage.sv
module hp_pwm_out_stage #(
  parameter int unsigned DUTY_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [DUTY_W-1:0] pos_i,
  input  logic [DUTY_W-1:0] next_duty_i,
  input  logic [DUTY_W-1:0] act_duty_i,
  output logic              pin_o
);
  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pin_q <= 1'b0;
    else if (!en_i)                 pin_q <= 1'b0;
    else if (load_i)                pin_q <= (next_duty_i != '0);
    else if (pos_i == act_duty_i)   pin_q <= 1'b0;   // fine-grained match clears
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/hp_pwm_gen.sv
module hp_pwm_gen
  import hp_pwm_pkg::*;
#(
  parameter  int unsigned NCH    = 3,
  parameter  int unsigned CNT_W  = 8,
  localparam int unsigned SEL_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned DUTY_W = CNT_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              tmr_clr_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DUTY_W-1:0] wr_data_i,
  output logic [NCH-1:0]    pwm_o,
  output logic              period_start_o
);
  logic [CNT_W-1:0]  tmr_q;
  phase_t            ph_q;
  logic              load;
  logic [DUTY_W-1:0] pos;
  logic              start_q;

  hp_pwm_timebase #(.CNT_W(CNT_W)) i_timebase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (enable_i),
    .clr_i   (tmr_clr_i),
    .period_i(period_i),
    .tmr_o   (tmr_q),
    .ph_o    (ph_q),
    .load_o  (load)
  );

  assign pos = {tmr_q, ph_q};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DUTY_W-1:0] shadow, active;
    logic              wr;

    assign wr = wr_en_i && (wr_sel_i == SEL_W'(c));

    hp_pwm_duty_buf #(.DUTY_W(DUTY_W)) i_buf (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr),
      .data_i  (wr_data_i),
      .load_i  (load),
      .shadow_o(shadow),
      .active_o(active)
    );

    hp_pwm_out_stage #(.DUTY_W(DUTY_W)) i_out (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (enable_i),
      .load_i     (load),
      .pos_i      (pos),
      .next_duty_i(shadow),
      .act_duty_i (active),
      .pin_o      (pwm_o[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= load;
  end

  assign period_start_o = start_q;
endmodule

// File: rtl/hp_pwm_chk.sv
module hp_pwm_chk
  import hp_pwm_pkg::*;
#(
  parameter int unsigned NCH   = 3,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             tmr_clr_i,
  input logic [NCH-1:0]   pwm_o,
  input logic             period_start_o,
  input logic [CNT_W-1:0] tmr_i,
  input phase_t           ph_i
);
  a_r2_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (pwm_o == '0) && !period_start_o && (tmr_i == '0) && (ph_i == '0));

  a_r1_start_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_o |-> $past(enable_i) && ($past(tmr_i) == '0) && ($past(ph_i) == '0));

  a_r1_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_start_o && !$past(tmr_clr_i)) |=> !period_start_o);

  for (genvar c = 0; c < NCH; c++) begin : g_rise
    a_r4_rise_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pwm_o[c]) |-> period_start_o);
  end
endmodule

bind hp_pwm_gen hp_pwm_chk #(.NCH(NCH), .CNT_W(CNT_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .enable_i      (enable_i),
  .tmr_clr_i     (tmr_clr_i),
  .pwm_o         (pwm_o),
  .period_start_o(period_start_o),
  .tmr_i         (tmr_q),
  .ph_i          (ph_q)
);

// File: tb/test_hp_pwm_gen.sv
`timescale 1ns/1ps
module test_hp_pwm_gen;
  localparam int NCH    = 3;
  localparam int CNT_W  = 8;
  localparam int SEL_W  = 2;
  localparam int DUTY_W = CNT_W + 2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              enable_i = 1'b0;
  logic              tmr_clr_i = 1'b0;
  logic [CNT_W-1:0]  period_i = '0;
  logic              wr_en_i = 1'b0;
  logic [SEL_W-1:0]  wr_sel_i = '0;
  logic [DUTY_W-1:0] wr_data_i = '0;
  logic [NCH-1:0]    pwm_o;
  logic              period_start_o;

  always #2.5 clk = ~clk;

  hp_pwm_gen #(.NCH(NCH), .CNT_W(CNT_W)) i_hp_pwm_gen (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .tmr_clr_i(tmr_clr_i),
    .period_i(period_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .pwm_o(pwm_o), .period_start_o(period_start_o)
  );

  typedef struct {
    logic           strobe;
    logic [NCH-1:0] pwm;
    string          tag;
  } exp_t;

  exp_t q[$];
  int   errors = 0;
  int   checks = 0;
  bit   done   = 1'b0;

  // bench model state
  int                k = 0;
  logic [DUTY_W-1:0] buf_m [NCH];
  logic [DUTY_W-1:0] act_m [NCH];

  task automatic check(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  // monitor: samples 1 ns after each edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(period_start_o == e.strobe, e.tag,
            $sformatf("strobe actual=%0b expected=%0b", period_start_o, e.strobe));
      check(pwm_o == e.pwm, e.tag,
            $sformatf("pwm actual=%b expected=%b", pwm_o, e.pwm));
    end
  end

  // driver: called right after a negedge with inputs set for the next edge
  task automatic step(input string tag);
    exp_t e;
    int pm;
    pm = (period_i == 0) ? 1 : int'(period_i);
    if (!enable_i) begin
      e.strobe = 1'b0;
      e.pwm    = '0;
      k        = 0;
    end else begin
      if (k == 0) for (int c = 0; c < NCH; c++) act_m[c] = buf_m[c];
      e.strobe = (k == 0);
      for (int c = 0; c < NCH; c++) e.pwm[c] = (k < int'(act_m[c]));
      k = tmr_clr_i ? 0 : ((k == 4*pm - 1) ? 0 : k + 1);
    end
    if (wr_en_i && int'(wr_sel_i) < NCH) buf_m[wr_sel_i] = wr_data_i;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    wr_en_i   = 1'b0;
    tmr_clr_i = 1'b0;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic wr(input int sel, input int val, input string tag);
    wr_en_i   = 1'b1;
    wr_sel_i  = SEL_W'(sel);
    wr_data_i = DUTY_W'(val);
    step(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin buf_m[c] = '0; act_m[c] = '0; end
    repeat (3) @(posedge clk);
    #1;
    check(pwm_o == '0 && period_start_o == 1'b0, "R9",
          $sformatf("reset pwm=%b strobe=%0b expected 000/0", pwm_o, period_start_o));
    @(negedge clk);
    rst_ni = 1'b1;
    run(3, "R9");

    // R9: zero buffers give a low pin on enable
    period_i = 8'd2;
    enable_i = 1'b1;
    run(8, "R9");
    enable_i = 1'b0;
    run(2, "R2");

    // R7: sel 3 is out of range
    period_i = 8'd5;
    wr(0, 13, "R7");
    wr(1, 0,  "R7");
    wr(2, 20, "R7");
    wr(3, 7,  "R7");
    enable_i = 1'b1;
    run(60, "R1 R3 R4 R7");          // k back to 0

    // R5: mid-period write
    run(6, "R5");
    wr(0, 11, "R5");
    run(13, "R5");
    run(20, "R5");                   // k at 0

    // R6: write on the restart edge
    wr(2, 3, "R6");
    run(19, "R6");
    run(20, "R6");

    // R8: restart mid-pulse
    run(9, "R8");
    tmr_clr_i = 1'b1;
    step("R8");
    run(25, "R8");

    // R2: disable mid-period, then short periods
    run(5, "R2");
    enable_i = 1'b0;
    run(4, "R2");
    period_i = 8'd1;
    wr(0, 2, "R2");
    wr(1, 4, "R2");
    wr(2, 1, "R2");
    enable_i = 1'b1;
    run(12, "R1 R3");
    enable_i = 1'b0;
    step("R2");
    period_i = 8'd0;
    enable_i = 1'b1;
    run(8, "R1");

    // R3: fine offsets in the last tick
    enable_i = 1'b0;
    step("R2");
    period_i = 8'd6;
    wr(0, 22, "R3");
    wr(1, 23, "R3");
    wr(2, 25, "R3");
    enable_i = 1'b1;
    run(48, "R3 R4");
    enable_i = 1'b0;
    run(2, "R2");

    @(posedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule